// File: doc/BRIEF.md
# Boundary-Scan Test Port with Capture-Only Instructions

This block is the serial test port of a memory device. A four-wire serial interface (test clock, mode select, data in, data out) drives the usual sixteen-state test controller. Through it an external tester loads a 3-bit instruction. That instruction chooses one data path: a one-bit pass-through stage, a fixed 32-bit identifier, or a pin-ring capture register whose length is set by a parameter. The tester then scans the chosen path.

The instruction set is reduced. Nothing scanned in is ever driven onto the device pins. The two instructions that would normally drive pins only capture the pin ring, the same way the sample instruction does. While either of them is active, the block raises an output-disable signal that sends the core's outputs to high impedance. The test reset (mode select held high) acts only on the test logic and leaves the memory core alone.

Top module: `tap_scan_port`

## Requirements
- R1: After the power-on reset (`rst_n` low for at least one rising `tck`), the controller is in test-logic-reset. The active instruction is the identifier code 3'b001, `tdo_oe` is 0 and `core_hiz` is 0.
- R2: From any controller state, five rising `tck` edges with `tms` high return it to test-logic-reset, and the active instruction becomes the identifier code again.
- R3: `tdi` is sampled on the rising edge of `tck`. `tdo` and `tdo_oe` update on the falling edge. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR, and `tdo` then shows bit 0 of the register being shifted.
- R4: In Capture-IR the instruction shift stage loads 3'b001, so the first three bits out of Shift-IR are 1, 0, 0.
- R5: A newly shifted instruction takes effect only as the controller leaves Update-IR. Until then the data path selection and `core_hiz` do not change.
- R6: Code 3'b001 selects the 32-bit identifier `ID_VALUE`. It loads in Capture-DR and shifts out least significant bit first.
- R7: Code 3'b111 and the unassigned codes 3'b011, 3'b101 and 3'b110 select a one-bit stage. That stage loads 0 in Capture-DR, so the output is 0 followed by `tdi` delayed by one shift.
- R8: Code 3'b100 selects the pin-ring register. It loads `ring_in` in Capture-DR and shifts out least significant bit first, with `core_hiz` at 0.
- R9: Codes 3'b000 and 3'b010 capture and shift the pin ring exactly as R8 does, and hold `core_hiz` at 1 while active.
- R10: The pin-ring register is `RING_LEN` bits long, with its top bit nearest `tdi`. A bit entered at `tdi` reaches `tdo` after `RING_LEN` shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous to `tck` |
| tms | input | 1 | Test mode select, steers the controller |
| tdi | input | 1 | Serial test data in |
| ring_in | input | RING_LEN | Parallel snapshot of the device pin ring |
| tdo | output | 1 | Serial test data out, valid when `tdo_oe` is 1 |
| tdo_oe | output | 1 | Drive enable for `tdo`; 0 means high impedance |
| core_hiz | output | 1 | Forces the core's outputs to high impedance |

## Verification
The bench uses the default parameters: a 69-bit pin ring and a 32-bit identifier. With these values, every capture, the full-length pass-through check and the identifier readout run at their real lengths. One table entry for each of the eight instruction codes means each reserved code and each output-disabling code is scanned at least once. The 69-bit ring also makes it possible to show that a bit needs exactly `RING_LEN` shifts to travel from input to output.

// File: rtl/tap_pkg.sv
// Shared types for the boundary-scan test port.
// Assumes a 3-bit instruction; the code points are fixed because a tester depends on them.
package tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PAU_DR  = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PAU_IR  = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_state_t;

    typedef enum logic [1:0] {
        PATH_RING   = 2'd0,
        PATH_IDENT  = 2'd1,
        PATH_SINGLE = 2'd2
    } dr_path_t;

    localparam int unsigned IR_W = 3;

    localparam logic [IR_W-1:0] OP_RING_HIZ  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDENT     = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE_Z  = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE    = 3'b100;
    localparam logic [IR_W-1:0] OP_PASS      = 3'b111;
    localparam logic [IR_W-1:0] IR_CAP_VALUE = 3'b001;

    // Maps an instruction to its data path; unassigned codes use the one-bit stage.
    function automatic dr_path_t path_of(input logic [IR_W-1:0] op);
        case (op)
            OP_RING_HIZ, OP_SAMPLE_Z, OP_SAMPLE: path_of = PATH_RING;
            OP_IDENT:                            path_of = PATH_IDENT;
            default:                             path_of = PATH_SINGLE;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state test controller, advanced on rising tck.
// Assumes rst_n is synchronous to tck; reset places the controller in test-logic-reset.
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next-state selection from the current state and tms.
    always_comb begin
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            default:   nxt = tms ? ST_SEL_DR : ST_IDLE;
        endcase
    end

    // State register with synchronous power-on reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

endmodule

// File: rtl/tap_ir.sv
// Instruction shift stage and active instruction.
// Assumes the controller state comes from tap_fsm; the active code changes only on leaving Update-IR or in reset.
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_shift,
    output logic [IR_W-1:0] ir_active
);

    // Shift stage: fixed pattern on capture, serial load toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                  ir_shift <= IR_CAP_VALUE;
        else if (state == ST_CAP_IR) ir_shift <= IR_CAP_VALUE;
        else if (state == ST_SH_IR)  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end

    // Active instruction: identifier in reset, shifted code on update.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_RESET) ir_active <= OP_IDENT;
        else if (state == ST_UPD_IR)     ir_active <= ir_shift;
    end

endmodule

// File: rtl/tap_dr.sv
// Data paths: one-bit pass stage, fixed identifier, and pin-ring capture register.
// Assumes only the path chosen by the active instruction captures or shifts; nothing drives the pins.
module tap_dr
    import tap_pkg::*;
#(
    parameter int unsigned RING_LEN = 69,
    parameter logic [31:0] ID_VALUE = 32'h0B72_9C05
) (
    input  logic                tck,
    input  logic                rst_n,
    input  tap_state_t          state,
    input  dr_path_t            path,
    input  logic                tdi,
    input  logic [RING_LEN-1:0] ring_in,
    output logic                dr_lsb
);

    logic                pass_q;
    logic [31:0]         id_q;
    logic [RING_LEN-1:0] ring_q;
    logic                cap;
    logic                sh;

    assign cap = (state == ST_CAP_DR);
    assign sh  = (state == ST_SH_DR);

    // One-bit stage: cleared on capture, takes tdi on shift.
    always_ff @(posedge tck) begin
        if (!rst_n)                                pass_q <= 1'b0;
        else if (path == PATH_SINGLE && cap)       pass_q <= 1'b0;
        else if (path == PATH_SINGLE && sh)        pass_q <= tdi;
    end

    // Identifier: loads the fixed value on capture, shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                                id_q <= ID_VALUE;
        else if (path == PATH_IDENT && cap)        id_q <= ID_VALUE;
        else if (path == PATH_IDENT && sh)         id_q <= {tdi, id_q[31:1]};
    end

    // Pin ring: snapshot on capture, top bit fed from tdi on shift.
    always_ff @(posedge tck) begin
        if (!rst_n)                                ring_q <= '0;
        else if (path == PATH_RING && cap)         ring_q <= ring_in;
        else if (path == PATH_RING && sh)          ring_q <= {tdi, ring_q[RING_LEN-1:1]};
    end

    // Serial output of the selected path.
    always_comb begin
        unique case (path)
            PATH_RING:  dr_lsb = ring_q[0];
            PATH_IDENT: dr_lsb = id_q[0];
            default:    dr_lsb = pass_q;
        endcase
    end

endmodule

// File: rtl/tap_scan_port.sv
// Top of the boundary-scan test port: controller, instruction, data paths and falling-edge output.
// Assumes rst_n is a power-on reset synchronous to tck; scan data never drives the device pins.
module tap_scan_port
    import tap_pkg::*;
#(
    parameter int unsigned RING_LEN = 69,
    parameter logic [31:0] ID_VALUE = 32'h0B72_9C05
) (
    input  logic                tck,
    input  logic                rst_n,
    input  logic                tms,
    input  logic                tdi,
    input  logic [RING_LEN-1:0] ring_in,
    output logic                tdo,
    output logic                tdo_oe,
    output logic                core_hiz
);

    tap_state_t      state;
    logic [IR_W-1:0] ir_shift;
    logic [IR_W-1:0] ir_active;
    dr_path_t        path;
    logic            dr_lsb;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck       (tck),
        .rst_n     (rst_n),
        .state     (state),
        .tdi       (tdi),
        .ir_shift  (ir_shift),
        .ir_active (ir_active)
    );

    assign path = path_of(ir_active);

    tap_dr #(
        .RING_LEN (RING_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck     (tck),
        .rst_n   (rst_n),
        .state   (state),
        .path    (path),
        .tdi     (tdi),
        .ring_in (ring_in),
        .dr_lsb  (dr_lsb)
    );

    // Output disable toward the core for the two capture-with-disable codes.
    assign core_hiz = (ir_active == OP_RING_HIZ) || (ir_active == OP_SAMPLE_Z);

    // Serial output and its enable, updated on the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (state == ST_SH_IR) begin
            tdo    <= ir_shift[0];
            tdo_oe <= 1'b1;
        end else if (state == ST_SH_DR) begin
            tdo    <= dr_lsb;
            tdo_oe <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/tap_scan_port_chk.sv
// Property checker for tap_scan_port, attached by bind.
// Assumes it observes the top's internal state, instruction and data-path output.
module tap_scan_port_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            rst_n,
    input logic            tms,
    input tap_state_t      state,
    input logic [IR_W-1:0] ir_shift,
    input logic [IR_W-1:0] ir_active,
    input logic            dr_lsb,
    input logic            tdo_oe,
    input logic            core_hiz
);

    logic [2:0] ones_run;

    // Counts consecutive rising edges with tms high, saturating at five.
    always_ff @(posedge tck) begin
        if (!rst_n)             ones_run <= 3'd0;
        else if (!tms)          ones_run <= 3'd0;
        else if (ones_run < 3'd5) ones_run <= ones_run + 3'd1;
    end

    // R1: test-logic-reset restores the identifier instruction.
    p_reset_ident_r1: assert property (@(posedge tck) disable iff (!rst_n)
        state == ST_RESET |=> ir_active == OP_IDENT);

    // R2: five high tms edges always land in test-logic-reset.
    p_five_ones_r2: assert property (@(posedge tck) disable iff (!rst_n)
        ones_run == 3'd5 |-> state == ST_RESET);

    // R3: the output drive is on only for the shift states.
    p_oe_shift_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_SH_DR && state != ST_SH_IR) |-> !tdo_oe);

    // R4: capture-IR loads the fixed pattern.
    p_capir_pattern_r4: assert property (@(posedge tck) disable iff (!rst_n)
        state == ST_CAP_IR |=> ir_shift == IR_CAP_VALUE);

    // R5: the active instruction holds outside update and reset.
    p_ir_hold_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_active));

    // R7: the one-bit stage reads 0 right after capture.
    p_single_zero_r7: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR && path_of(ir_active) == PATH_SINGLE) |=> !dr_lsb);

    // R9: updating to a disabling code raises the core disable.
    p_hiz_update_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_UPD_IR && (ir_shift == OP_RING_HIZ || ir_shift == OP_SAMPLE_Z)) |=> core_hiz);

endmodule

bind tap_scan_port tap_scan_port_chk u_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .tms       (tms),
    .state     (state),
    .ir_shift  (ir_shift),
    .ir_active (ir_active),
    .dr_lsb    (dr_lsb),
    .tdo_oe    (tdo_oe),
    .core_hiz  (core_hiz)
);

// File: tb/tap_scan_port_bench.sv
module tap_scan_port_bench;

    localparam int unsigned RING_LEN = 69;
    localparam logic [31:0] ID_VALUE = 32'h0B72_9C05;
    localparam int unsigned MAXW     = 128;

    // Vector: {code[2:0], path[1:0] (0 ring, 1 ident, 2 single), hiz}
    localparam logic [5:0] VECS [8] = '{
        6'b000_00_1, 6'b001_01_0, 6'b010_00_1, 6'b011_10_0,
        6'b100_00_0, 6'b101_10_0, 6'b110_10_0, 6'b111_10_0
    };

    logic                tck = 1'b0;
    logic                rst_n = 1'b0;
    logic                tms = 1'b1;
    logic                tdi = 1'b0;
    logic [RING_LEN-1:0] ring_in = '0;
    logic                tdo;
    logic                tdo_oe;
    logic                core_hiz;

    int nvec = 0;
    int nbad = 0;

    tap_scan_port #(.RING_LEN(RING_LEN), .ID_VALUE(ID_VALUE)) u_tap_scan_port (
        .tck      (tck),
        .rst_n    (rst_n),
        .tms      (tms),
        .tdi      (tdi),
        .ring_in  (ring_in),
        .tdo      (tdo),
        .tdo_oe   (tdo_oe),
        .core_hiz (core_hiz)
    );

    always #2 tck = ~tck;

    task automatic check(input string req, input logic [MAXW-1:0] act, input logic [MAXW-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One tck cycle: drive after the falling edge, sample tdo there, then pass the rising edge.
    task automatic step(input logic m, input logic d, output logic so, output logic soe);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        so  = tdo;
        soe = tdo_oe;
        @(posedge tck);
        #1;
    endtask

    task automatic go_reset();
        logic a, b;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, a, b);
    endtask

    // From idle: load a code; returns the three bits seen in Shift-IR.
    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap, output logic oe_all);
        logic a, b;
        step(1'b1, 1'b0, a, b);
        step(1'b1, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
        oe_all = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], cap[i], b);
            oe_all &= b;
        end
        step(1'b1, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
    endtask

    // From idle: scan n bits through the data path, back to idle.
    task automatic scan_dr(input int n, input logic [MAXW-1:0] din, output logic [MAXW-1:0] dout, output logic oe_all);
        logic a, b;
        dout = '0;
        step(1'b1, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
        oe_all = 1'b1;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], dout[i], b);
            oe_all &= b;
        end
        step(1'b1, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
    endtask

    initial begin
        #600000;
        nbad++;
        nvec++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [2:0]      cap;
        logic            oe, a, b;
        logic [MAXW-1:0] dout, din, exp;
        int              len;

        repeat (3) @(posedge tck);
        #1;
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        check("R1 tdo_oe after reset", tdo_oe, 0);
        check("R1 core_hiz after reset", core_hiz, 0);
        step(1'b0, 1'b0, a, b);
        check("R3 tdo_oe in idle", b, 0);
        // R1 and R6: identifier selected without any instruction load
        scan_dr(32, '0, dout, oe);
        check("R1 R6 identifier after reset", dout, MAXW'(ID_VALUE));
        check("R3 tdo_oe during Shift-DR", oe, 1);

        // Table of all eight codes
        for (int v = 0; v < 8; v++) begin
            ring_in = {RING_LEN{1'b0}} | {3{32'hC3A5_0F96 ^ (32'h1111_1111 * v)}};
            load_ir(VECS[v][5:3], cap, oe);
            check("R4 captured instruction bits", cap, 3'b001);
            check("R3 tdo_oe during Shift-IR", oe, 1);
            check("R8 R9 core_hiz for code", core_hiz, VECS[v][0]);
            din = {4{32'h5A3C_96E1 + v}};
            case (VECS[v][2:1])
                2'd0: begin len = RING_LEN; exp = MAXW'(ring_in); end
                2'd1: begin len = 32;       exp = MAXW'(ID_VALUE); end
                default: begin len = 8;     exp = MAXW'({din[6:0], 1'b0}); end
            endcase
            scan_dr(len, din, dout, oe);
            check("R6 R7 R8 R9 scan result for code", dout & ((MAXW'(1) << len) - 1), exp);
        end

        // R10: bit entered at tdi needs RING_LEN shifts to reach tdo
        go_reset();
        step(1'b0, 1'b0, a, b);
        load_ir(3'b100, cap, oe);
        ring_in = '0;
        din = MAXW'(8'hB5);
        scan_dr(RING_LEN + 8, din, dout, oe);
        check("R10 ring length", dout >> RING_LEN, MAXW'(8'hB5));
        check("R10 captured zero ring", dout & ((MAXW'(1) << RING_LEN) - 1), '0);

        // R5: code change held until Update-IR is left
        step(1'b1, 1'b0, a, b);
        step(1'b1, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
        step(1'b1, 1'b0, a, b);
        check("R5 core_hiz before update (Exit1-IR)", core_hiz, 0);
        step(1'b1, 1'b0, a, b);
        check("R5 core_hiz in Update-IR", core_hiz, 0);
        step(1'b0, 1'b0, a, b);
        check("R5 R9 core_hiz after update", core_hiz, 1);

        // R2: five high tms from mid Shift-DR, under the pass instruction
        load_ir(3'b111, cap, oe);
        step(1'b1, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
        step(1'b0, 1'b0, a, b);
        step(1'b0, 1'b1, a, b);
        go_reset();
        check("R2 tdo_oe in reset", tdo_oe, 0);
        check("R2 core_hiz in reset", core_hiz, 0);
        step(1'b0, 1'b0, a, b);
        scan_dr(32, '0, dout, oe);
        check("R2 identifier after tms reset", dout, MAXW'(ID_VALUE));

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule